// File: doc/BRIEF.md
# Segment Limit and Rights Checker

This block decides, for one memory access at a time, whether the access may go through the segment it names. It receives the address, the access size and the access kind, along with the segment's base, limit and attribute bits and the current mode bits. One clock later it reports a single verdict: pass, or a general-protection fault with a cause code.

Checking happens only while protection is on and the machine is not executing 64-bit code. In that case the access rights are checked first, and then the offset is checked against the limit. The limit rule handles both expand-up and expand-down segments, and it also covers a limit that is numerically below the base. The end of the access is computed one bit wider than the address, so a carry out of the address range is still counted as a limit violation.

A registered state machine holds the verdict. It has three states. `ST_IDLE` means no result is held. `ST_PASS` means the last request was allowed. `ST_FAULT` means the last request was refused. Each clock edge follows one of three transitions: *accept* (a valid request with no violation goes to `ST_PASS`), *reject* (a valid request with a violation goes to `ST_FAULT`) and *drain* (no request goes to `ST_IDLE`). Any state can take any of these transitions. Reset returns the machine to `ST_IDLE`.

Top module: `seg_guard`

## Requirements
- R1: Checking is bypassed, and the verdict is pass, when `mode_pe` is 0 or when `mode_lma` and `mode_cs_long` are both 1. Either mode bit alone does not bypass checking.
- R2: A write (`req_kind` = 1) to a segment with `seg_wr` = 0 faults with cause 1.
- R3: A data read (`req_kind` = 0) from a segment with `seg_rd` = 0 faults with cause 2. Instruction fetches (`req_kind` 2 or 3) and writes ignore `seg_rd`.
- R4: For an expand-up segment (`seg_down` = 0) with limit ≥ base, a limit fault (cause 3) is raised exactly when limit < addr + size.
- R5: For an expand-up segment with limit < base, a limit fault is raised exactly when limit < addr + size and addr < base.
- R6: For an expand-down segment (`seg_down` = 1) with limit ≥ base, a limit fault is raised exactly when addr ≤ limit and addr + size ≥ base.
- R7: For an expand-down segment with limit < base, a limit fault is raised exactly when addr ≤ limit or addr + size ≥ base.
- R8: addr + size is formed one bit wider than the address, so a sum that overflows the address width counts as exceeding any limit.
- R9: When several violations occur together, the write-rights cause (1) wins over the read-rights cause (2), and the read-rights cause wins over the limit cause (3).
- R10: The verdict appears on the outputs one clock after `req_valid`. A cycle without a request leaves `rsp_valid` low in the following cycle. After reset all outputs are 0.
- R11: `rsp_pass` and `rsp_fault` are never high together. Whenever `rsp_pass` is high, `rsp_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | ADDR_W | Access address (segment offset) |
| req_size | input | SIZE_W | Access size in bytes |
| req_kind | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| seg_rd | input | 1 | Segment is readable |
| seg_wr | input | 1 | Segment is writable |
| seg_down | input | 1 | Segment expands down |
| mode_pe | input | 1 | Protection enabled |
| mode_lma | input | 1 | Long mode active |
| mode_cs_long | input | 1 | Code segment is a 64-bit segment |
| rsp_valid | output | 1 | A verdict is held |
| rsp_pass | output | 1 | Access allowed |
| rsp_fault | output | 1 | General-protection fault |
| rsp_cause | output | 2 | 0 none, 1 write right, 2 read right, 3 limit |

## Verification
All state in this block is the verdict register and the cause register, so any wrong internal state becomes visible on the outputs in the very next cycle. If the state register lands wrong, `rsp_pass` or `rsp_fault` flips, or `rsp_valid` stays high after a cycle with no request. If the cause register lands wrong, the fault shows the wrong code, or a nonzero code appears next to a pass. The vector table walks every limit region on each side of its boundary and the overflow edge. A back-to-back sequence shows that each verdict belongs to the request of the previous cycle and not to an older one.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    typedef enum logic [1:0] {
        KIND_READ      = 2'd0,
        KIND_WRITE     = 2'd1,
        KIND_FETCH     = 2'd2,
        KIND_FETCH_ALT = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_WRITE = 2'd1,
        CAUSE_READ  = 2'd2,
        CAUSE_LIMIT = 2'd3
    } gp_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_FAULT = 2'd2
    } verdict_st_e;

endpackage

// File: rtl/seg_mode_gate.sv
module seg_mode_gate (
    input  logic pe,
    input  logic lma,
    input  logic cs_long,
    output logic check_en
);
    // 64-bit code and unprotected operation both skip all checks
    always_comb begin
        check_en = pe && !(lma && cs_long);
    end
endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
    import seg_guard_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       can_read,
    input  logic       can_write,
    output logic       wr_viol,
    output logic       rd_viol
);
    always_comb begin
        wr_viol = (kind == KIND_WRITE) && !can_write;
        rd_viol = (kind == KIND_READ)  && !can_read;
    end
endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic              down,
    output logic              lim_viol
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] end_ext;
    logic [EXT_W-1:0] lim_ext;
    logic [EXT_W-1:0] base_ext;
    logic             wrapped;
    logic             past_lim;
    logic             below_base;
    logic             at_or_under_lim;
    logic             reach_base;

    always_comb begin
        end_ext         = {1'b0, addr} + EXT_W'(size);
        lim_ext         = {1'b0, limit};
        base_ext        = {1'b0, base};
        wrapped         = limit < base;
        past_lim        = lim_ext < end_ext;
        below_base      = addr < base;
        at_or_under_lim = addr <= limit;
        reach_base      = end_ext >= base_ext;
        unique case ({down, wrapped})
            2'b00:   lim_viol = past_lim;
            2'b01:   lim_viol = past_lim && below_base;
            2'b10:   lim_viol = at_or_under_lim && reach_base;
            default: lim_viol = at_or_under_lim || reach_base;
        endcase
    end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              seg_rd,
    input  logic              seg_wr,
    input  logic              seg_down,
    input  logic              mode_pe,
    input  logic              mode_lma,
    input  logic              mode_cs_long,
    output logic              rsp_valid,
    output logic              rsp_pass,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause
);
    localparam int EXT_W = ADDR_W + 1;

    logic        check_en;
    logic        wr_viol;
    logic        rd_viol;
    logic        lim_viol;
    gp_cause_e   cause_d;
    gp_cause_e   cause_q;
    verdict_st_e state_q;
    verdict_st_e state_d;

    seg_mode_gate u_gate (
        .pe       (mode_pe),
        .lma      (mode_lma),
        .cs_long  (mode_cs_long),
        .check_en (check_en)
    );

    seg_rights_chk u_rights (
        .kind      (req_kind),
        .can_read  (seg_rd),
        .can_write (seg_wr),
        .wr_viol   (wr_viol),
        .rd_viol   (rd_viol)
    );

    seg_limit_chk #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_limit (
        .addr     (req_addr),
        .size     (req_size),
        .base     (seg_base),
        .limit    (seg_limit),
        .down     (seg_down),
        .lim_viol (lim_viol)
    );

    // Cause priority: write right, then read right, then limit
    always_comb begin
        if (!check_en)     cause_d = CAUSE_NONE;
        else if (wr_viol)  cause_d = CAUSE_WRITE;
        else if (rd_viol)  cause_d = CAUSE_READ;
        else if (lim_viol) cause_d = CAUSE_LIMIT;
        else               cause_d = CAUSE_NONE;
    end

    // Transitions: accept, reject, drain
    always_comb begin
        if (!req_valid)                state_d = ST_IDLE;
        else if (cause_d == CAUSE_NONE) state_d = ST_PASS;
        else                           state_d = ST_FAULT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= req_valid ? cause_d : CAUSE_NONE;
        end
    end

    always_comb begin
        rsp_cause = cause_q;
        unique case (state_q)
            ST_IDLE:  begin rsp_valid = 1'b0; rsp_pass = 1'b0; rsp_fault = 1'b0; end
            ST_PASS:  begin rsp_valid = 1'b1; rsp_pass = 1'b1; rsp_fault = 1'b0; end
            ST_FAULT: begin rsp_valid = 1'b1; rsp_pass = 1'b0; rsp_fault = 1'b1; end
            default:  begin rsp_valid = 1'b0; rsp_pass = 1'b0; rsp_fault = 1'b0; end
        endcase
    end

    // Port-level view used by the properties below
    logic             chk_on_a;
    logic [EXT_W-1:0] end_a;
    always_comb begin
        chk_on_a = mode_pe && !(mode_lma && mode_cs_long);
        end_a    = EXT_W'(req_addr) + EXT_W'(req_size);
    end

    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !chk_on_a) |=> (rsp_pass && rsp_cause == 2'd0));

    p_write_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_on_a && req_kind == 2'd1 && !seg_wr)
        |=> (rsp_fault && rsp_cause == 2'd1));

    p_read_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_on_a && req_kind == 2'd0 && !seg_rd)
        |=> (rsp_fault && rsp_cause == 2'd2));

    p_up_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_on_a && req_kind[1] && !seg_down &&
         seg_limit >= seg_base && EXT_W'(seg_limit) < end_a)
        |=> (rsp_fault && rsp_cause == 2'd3));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_pass_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pass |-> (!rsp_fault && rsp_cause == 2'd0));

endmodule

// File: tb/seg_guard_bench.sv
module seg_guard_bench;
    localparam int PERIOD = 10;
    localparam int AW = 32;
    localparam int SW = 4;

    typedef struct packed {
        logic [1:0]    kind;
        logic          rd;
        logic          wr;
        logic          down;
        logic          pe;
        logic          lma;
        logic          csl;
        logic [AW-1:0] addr;
        logic [SW-1:0] size;
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
        logic          fault;
        logic [1:0]    cause;
    } vec_t;

    localparam int NV = 23;
    // kind: 0 read, 1 write, 2 fetch; cause: 0 none, 1 write, 2 read, 3 limit
    localparam vec_t VECS [NV] = '{
        '{2'd1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 32'h2000,4'd4,32'h0,32'h100, 1'b0,2'd0}, // R1 pe off
        '{2'd1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1, 32'h2000,4'd4,32'h0,32'h100, 1'b0,2'd0}, // R1 64-bit
        '{2'd1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0, 32'h2000,4'd4,32'h0,32'h100, 1'b1,2'd1}, // R1 lma only
        '{2'd0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1, 32'h10,4'd4,32'h0,32'hFF,    1'b1,2'd2}, // R1 cs long only
        '{2'd1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0, 32'h10,4'd4,32'h0,32'hFF,    1'b0,2'd0}, // R2 R3 write ok
        '{2'd2,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 32'h10,4'd4,32'h0,32'hFF,    1'b0,2'd0}, // R3 fetch
        '{2'd0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0, 32'h10,4'd4,32'h0,32'hFF,    1'b0,2'd0}, // R3 read ok
        '{2'd0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0, 32'hFC,4'd4,32'h0,32'hFF,    1'b1,2'd3}, // R4 over
        '{2'd0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0, 32'hFB,4'd4,32'h0,32'hFF,    1'b0,2'd0}, // R4 edge
        '{2'd0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0, 32'h200,4'd4,32'h1000,32'h100, 1'b1,2'd3}, // R5
        '{2'd0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0, 32'h2000,4'd4,32'h1000,32'h100,1'b0,2'd0}, // R5
        '{2'd0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0, 32'h10,4'd4,32'h1000,32'h100,  1'b0,2'd0}, // R5
        '{2'd0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0, 32'h180,4'd4,32'h100,32'h200,  1'b1,2'd3}, // R6
        '{2'd0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0, 32'h300,4'd4,32'h100,32'h200,  1'b0,2'd0}, // R6
        '{2'd0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0, 32'h10,4'd4,32'h100,32'h200,   1'b0,2'd0}, // R6
        '{2'd0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0, 32'h80,4'd4,32'h1000,32'h100,  1'b1,2'd3}, // R7
        '{2'd0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0, 32'h800,4'd4,32'h1000,32'h100, 1'b0,2'd0}, // R7
        '{2'd0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0, 32'hFFE,4'd4,32'h1000,32'h100, 1'b1,2'd3}, // R7
        '{2'd2,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0, 32'hFFFFFFFE,4'd4,32'h0,32'hFFFFFFFF, 1'b1,2'd3}, // R8
        '{2'd2,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0, 32'hFFFFFFFB,4'd4,32'h0,32'hFFFFFFFF, 1'b0,2'd0}, // R8
        '{2'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 32'h300,4'd4,32'h0,32'hFF,    1'b1,2'd1}, // R9
        '{2'd0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 32'h300,4'd4,32'h0,32'hFF,    1'b1,2'd2}, // R9
        '{2'd3,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 32'h300,4'd4,32'h0,32'hFF,    1'b1,2'd3}  // R9
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic [1:0]    req_kind = '0;
    logic [AW-1:0] seg_base = '0;
    logic [AW-1:0] seg_limit = '0;
    logic          seg_rd = 1'b0;
    logic          seg_wr = 1'b0;
    logic          seg_down = 1'b0;
    logic          mode_pe = 1'b0;
    logic          mode_lma = 1'b0;
    logic          mode_cs_long = 1'b0;
    logic          rsp_valid;
    logic          rsp_pass;
    logic          rsp_fault;
    logic [1:0]    rsp_cause;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    seg_guard #(.ADDR_W(AW), .SIZE_W(SW)) u_seg_guard (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_addr (req_addr), .req_size (req_size), .req_kind (req_kind),
        .seg_base (seg_base), .seg_limit (seg_limit), .seg_rd (seg_rd),
        .seg_wr (seg_wr), .seg_down (seg_down), .mode_pe (mode_pe),
        .mode_lma (mode_lma), .mode_cs_long (mode_cs_long),
        .rsp_valid (rsp_valid), .rsp_pass (rsp_pass),
        .rsp_fault (rsp_fault), .rsp_cause (rsp_cause)
    );

    // got/exp packed as {valid, pass, fault, cause}
    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = {rsp_valid, rsp_pass, rsp_fault, rsp_cause};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got v/p/f/c=%b expected %b", req, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        req_valid    = 1'b1;
        req_kind     = v.kind;
        seg_rd       = v.rd;
        seg_wr       = v.wr;
        seg_down     = v.down;
        mode_pe      = v.pe;
        mode_lma     = v.lma;
        mode_cs_long = v.csl;
        req_addr     = v.addr;
        req_size     = v.size;
        seg_base     = v.base;
        seg_limit    = v.limit;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset state", 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", 5'b00000);

        // table walk: drive at a falling edge, result after the next rising edge
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            check($sformatf("vector %0d (R1..R9, R11)", i),
                  {1'b1, ~VECS[i].fault, VECS[i].fault, VECS[i].cause});
        end

        // R10: drain transition clears the verdict
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 drain", 5'b00000);

        // R10: back-to-back pass then fault then pass
        apply(VECS[8]);
        @(negedge clk);
        check("R10 b2b first", 5'b11000);
        apply(VECS[7]);
        @(negedge clk);
        check("R10 b2b second", 5'b10111);
        apply(VECS[6]);
        @(negedge clk);
        check("R10 b2b third", 5'b11000);

        // R10: reset while a fault is held
        apply(VECS[20]);
        @(negedge clk);
        check("R9 held fault", 5'b10101);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 reset clears", 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle again", 5'b00000);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule